// File: doc/BRIEF.md
# Stream Entry Configuration Checker

This block inspects a stream table entry that has already been fetched and decides what happens to the transaction tied to it. The entry arrives as parallel fields with a one-cycle start strobe. One cycle later the block gives exactly one verdict: abort silently, bypass translation, go on to stage-1 translation, or raise a bad-entry fault.

Abort and bypass end processing without any fault. Entries that ask for a feature this translation unit lacks are reported as bad entries: stage-2 translation, more than one context descriptor, or the stall fault model. Only on the proceed path is the context descriptor pointer forwarded, aligned down to a 64-byte boundary, so the next stage can fetch the descriptor. Fetching the entry and decoding the descriptor are not part of this block.

Top module: `ste_entry_checker`

## Requirements
- R1: An entry with `ent_valid_i` low yields `bad_entry_o`, whatever its other fields hold.
- R2: A valid entry whose config has bit 2 clear (config 0xx) yields `aborted_o` with `bad_entry_o` low.
- R3: A valid entry with config 3'b100 yields `bypassed_o` with `bad_entry_o` low.
- R4: A valid entry with config bits 2 and 1 both set (3'b110 or 3'b111, stage 2 enabled) yields `bad_entry_o`.
- R5: A valid config 3'b101 entry with a nonzero `ent_cd_max_i` yields `bad_entry_o`.
- R6: A valid config 3'b101 entry with `ent_stall_dis_i` set yields `bad_entry_o`.
- R7: The checks take priority in this order: valid, abort, bypass, stage 2, descriptor count, stall. Only when all of them pass is `proceed_o` raised.
- R8: `done_o` pulses in the cycle after `start_i`, and the verdict and pointer update only then. Without a start they hold, whatever the input fields do.
- R9: With `proceed_o`, `ctx_ptr_o` equals `ent_ctx_ptr_i` with its low 6 bits forced to zero. With any other verdict it is zero.
- R10: After reset, every output is zero. After each start, exactly one of the four verdict flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Entry fields are valid, evaluate |
| ent_valid_i | input | 1 | Entry valid bit |
| ent_cfg_i | input | 3 | Config field: 0xx abort, 100 bypass, 101 stage 1, 11x stage 2 |
| ent_cd_max_i | input | CDMAX_W | Maximum context descriptor count field |
| ent_stall_dis_i | input | 1 | Stage-1 stall-disable bit |
| ent_ctx_ptr_i | input | PTR_W | Context descriptor pointer field |
| done_o | output | 1 | Verdict updated this cycle |
| aborted_o | output | 1 | Silent abort verdict |
| bypassed_o | output | 1 | Bypass verdict |
| proceed_o | output | 1 | Continue to stage-1 translation |
| bad_entry_o | output | 1 | Bad-entry fault |
| ctx_ptr_o | output | PTR_W | Aligned context pointer, zero unless proceeding |

## Verification
The conditions that can collide are the separate reasons for rejection. An invalid entry can also select abort. A stage-2 config can come with a nonzero descriptor count and a stall bit. Abort or bypass can come with unsupported fields that must be ignored. An exhaustive sweep over valid, all eight configs, every descriptor count and the stall bit creates every such overlap. Each verdict is compared with a priority function in the bench and the pointer with an arithmetic mask. A hold cycle with scrambled inputs follows every start, to judge that the result does not move.

// File: rtl/ste_chk_pkg.sv
package ste_chk_pkg;
  typedef enum logic [1:0] {
    VD_ABORT   = 2'd0,
    VD_BYPASS  = 2'd1,
    VD_PROCEED = 2'd2,
    VD_BAD     = 2'd3
  } verdict_e;

  localparam logic [2:0] CFG_BYPASS = 3'b100;
  localparam logic [2:0] CFG_S1     = 3'b101;
endpackage

// File: rtl/ste_cfg_classify.sv
module ste_cfg_classify
  import ste_chk_pkg::*;
#(
  parameter int unsigned CDMAX_W = 5
) (
  input  logic               valid_i,
  input  logic [2:0]         cfg_i,
  input  logic [CDMAX_W-1:0] cd_max_i,
  input  logic               stall_dis_i,
  output verdict_e           verdict_o
);
  logic xlat_en, s2_en, multi_cd;

  assign xlat_en  = cfg_i[2];
  assign s2_en    = cfg_i[2] & cfg_i[1];
  assign multi_cd = |cd_max_i;

  // fixed priority chain
  always_comb begin
    if (!valid_i)                  verdict_o = VD_BAD;
    else if (!xlat_en)             verdict_o = VD_ABORT;
    else if (cfg_i == CFG_BYPASS)  verdict_o = VD_BYPASS;
    else if (s2_en)                verdict_o = VD_BAD;
    else if (multi_cd)             verdict_o = VD_BAD;
    else if (stall_dis_i)          verdict_o = VD_BAD;
    else                           verdict_o = VD_PROCEED;
  end
endmodule

// File: rtl/ste_ptr_align.sv
module ste_ptr_align #(
  parameter int unsigned PTR_W   = 48,
  parameter int unsigned ALIGN_W = 6
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] ptr_o
);
  for (genvar i = 0; i < PTR_W; i++) begin : g_bit
    if (i < ALIGN_W) begin : g_zero
      assign ptr_o[i] = 1'b0;
    end else begin : g_pass
      assign ptr_o[i] = ptr_i[i];
    end
  end
endmodule

// File: rtl/ste_result_reg.sv
module ste_result_reg
  import ste_chk_pkg::*;
#(
  parameter int unsigned PTR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  verdict_e         verdict_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             done_o,
  output logic             aborted_o,
  output logic             bypassed_o,
  output logic             proceed_o,
  output logic             bad_o,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      aborted_o  <= 1'b0;
      bypassed_o <= 1'b0;
      proceed_o  <= 1'b0;
      bad_o      <= 1'b0;
      ptr_o      <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        aborted_o  <= (verdict_i == VD_ABORT);
        bypassed_o <= (verdict_i == VD_BYPASS);
        proceed_o  <= (verdict_i == VD_PROCEED);
        bad_o      <= (verdict_i == VD_BAD);
        ptr_o      <= (verdict_i == VD_PROCEED) ? ptr_i : '0;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable({aborted_o, bypassed_o, proceed_o, bad_o, ptr_o}));

  p_one_verdict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({aborted_o, bypassed_o, proceed_o, bad_o}) == 1));
endmodule

// File: rtl/ste_entry_checker.sv
module ste_entry_checker
  import ste_chk_pkg::*;
#(
  parameter int unsigned PTR_W   = 48,
  parameter int unsigned CDMAX_W = 5,
  parameter int unsigned ALIGN_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               ent_valid_i,
  input  logic [2:0]         ent_cfg_i,
  input  logic [CDMAX_W-1:0] ent_cd_max_i,
  input  logic               ent_stall_dis_i,
  input  logic [PTR_W-1:0]   ent_ctx_ptr_i,
  output logic               done_o,
  output logic               aborted_o,
  output logic               bypassed_o,
  output logic               proceed_o,
  output logic               bad_entry_o,
  output logic [PTR_W-1:0]   ctx_ptr_o
);
  verdict_e         verdict;
  logic [PTR_W-1:0] ptr_aligned;

  ste_cfg_classify #(.CDMAX_W(CDMAX_W)) i_classify (
    .valid_i     (ent_valid_i),
    .cfg_i       (ent_cfg_i),
    .cd_max_i    (ent_cd_max_i),
    .stall_dis_i (ent_stall_dis_i),
    .verdict_o   (verdict)
  );

  ste_ptr_align #(.PTR_W(PTR_W), .ALIGN_W(ALIGN_W)) i_align (
    .ptr_i (ent_ctx_ptr_i),
    .ptr_o (ptr_aligned)
  );

  ste_result_reg #(.PTR_W(PTR_W)) i_result (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .verdict_i  (verdict),
    .ptr_i      (ptr_aligned),
    .done_o     (done_o),
    .aborted_o  (aborted_o),
    .bypassed_o (bypassed_o),
    .proceed_o  (proceed_o),
    .bad_o      (bad_entry_o),
    .ptr_o      (ctx_ptr_o)
  );

  p_invalid_bad_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ent_valid_i) |=> bad_entry_o);

  p_abort_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ent_valid_i && !ent_cfg_i[2]) |=> (aborted_o && !bad_entry_o));

  p_bypass_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ent_valid_i && ent_cfg_i == CFG_BYPASS) |=> (bypassed_o && !bad_entry_o));

  p_stage2_bad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ent_valid_i && ent_cfg_i[2] && ent_cfg_i[1]) |=> bad_entry_o);

  p_done_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_no_spurious_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_ptr_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ctx_ptr_o[ALIGN_W-1:0] == '0));

  p_ptr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !proceed_o |-> (ctx_ptr_o == '0));
endmodule

// File: tb/test_ste_entry_checker.sv
`timescale 1ns/1ps
module test_ste_entry_checker;
  localparam int PTR_W   = 48;
  localparam int CDMAX_W = 5;
  localparam int ALIGN_W = 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               valid = 1'b0;
  logic [2:0]         cfg = '0;
  logic [CDMAX_W-1:0] cdmax = '0;
  logic               stall = 1'b0;
  logic [PTR_W-1:0]   ptr = '0;
  logic               done, aborted, bypassed, proceed, bad;
  logic [PTR_W-1:0]   ptr_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ste_entry_checker #(.PTR_W(PTR_W), .CDMAX_W(CDMAX_W), .ALIGN_W(ALIGN_W)) i_ste_entry_checker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ent_valid_i(valid),
    .ent_cfg_i(cfg), .ent_cd_max_i(cdmax), .ent_stall_dis_i(stall),
    .ent_ctx_ptr_i(ptr), .done_o(done), .aborted_o(aborted),
    .bypassed_o(bypassed), .proceed_o(proceed), .bad_entry_o(bad),
    .ctx_ptr_o(ptr_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags packed {aborted, bypassed, proceed, bad}
  function automatic logic [3:0] exp_flags(logic v, logic [2:0] c, logic [CDMAX_W-1:0] m, logic s);
    if (!v)                 return 4'b0001;
    if (!c[2])              return 4'b1000;
    if (c == 3'b100)        return 4'b0100;
    if (c[1])               return 4'b0001;
    if (m != 0)             return 4'b0001;
    if (s)                  return 4'b0001;
    return 4'b0010;
  endfunction

  function automatic string req_of(logic v, logic [2:0] c, logic [CDMAX_W-1:0] m, logic s);
    if (!v)          return "R1";
    if (!c[2])       return "R2";
    if (c == 3'b100) return "R3";
    if (c[1])        return "R4";
    if (m != 0)      return "R5";
    if (s)           return "R6";
    return "R7";
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [3:0]       ef;
    logic [PTR_W-1:0] ep;
    logic [3:0]       held_f;
    logic [PTR_W-1:0] held_p;
    int               idx;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {58'd0, done, aborted, bypassed, proceed, bad, 1'b0}, 64'd0);
    chk("R10 reset ptr", {16'd0, ptr_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 no done without start", {63'd0, done}, 64'd0);
    idx = 0;
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 8; c++)
        for (int m = 0; m < (1 << CDMAX_W); m++)
          for (int s = 0; s < 2; s++) begin
            valid = v[0];
            cfg   = c[2:0];
            cdmax = m[CDMAX_W-1:0];
            stall = s[0];
            ptr   = {idx[15:0] ^ 16'h5a5a, 32'h9E3779B9 * (idx + 1)};
            start = 1'b1;
            ef = exp_flags(valid, cfg, cdmax, stall);
            ep = ef[1] ? (ptr & ~((PTR_W)'(64'd63))) : '0;
            @(negedge clk);
            start = 1'b0;
            chk("R8 done one cycle after start", {63'd0, done}, 64'd1);
            chk({req_of(valid, cfg, cdmax, stall), " verdict flags"},
                {60'd0, aborted, bypassed, proceed, bad}, {60'd0, ef});
            chk("R9 context pointer", {16'd0, ptr_out}, {16'd0, ep});
            chk("R10 single verdict", 64'($countones({aborted, bypassed, proceed, bad})), 64'd1);
            held_f = {aborted, bypassed, proceed, bad};
            held_p = ptr_out;
            // scramble inputs with no start: result must hold
            valid = ~valid;
            cfg   = ~cfg;
            cdmax = ~cdmax;
            stall = ~stall;
            ptr   = ~ptr;
            @(negedge clk);
            chk("R8 done low without start", {63'd0, done}, 64'd0);
            chk("R8 verdict held", {60'd0, aborted, bypassed, proceed, bad}, {60'd0, held_f});
            chk("R8 pointer held", {16'd0, ptr_out}, {16'd0, held_p});
            idx++;
          end
    // back-to-back starts: stage2+stall+cdmax overlap, then proceed
    valid = 1'b1; cfg = 3'b111; cdmax = 5'd3; stall = 1'b1; ptr = 48'hFFFF_FFFF_FFFF;
    start = 1'b1;
    @(negedge clk);
    chk("R4 overlapped faults bad", {63'd0, bad}, 64'd1);
    chk("R9 pointer zero on bad", {16'd0, ptr_out}, 64'd0);
    cfg = 3'b101; cdmax = '0; stall = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 back-to-back proceed", {60'd0, aborted, bypassed, proceed, bad}, 64'd2);
    chk("R9 all-ones pointer aligned", {16'd0, ptr_out}, 64'h0000_FFFF_FFFF_FFC0);
    chk("R8 done held across back-to-back", {63'd0, done}, 64'd1);
    finished = 1;
    summary();
  end
endmodule